// File: doc/BRIEF.md
# Upconverter Reset and Start Sequencer

This block is the control point for a digital upconverter datapath. It merges two reset sources, the active-low reset pin and a reset command written over the control bus, into one internal reset condition. After any reset the datapath does not restart when reset goes away. It stays frozen with the NCO accumulators held at zero, the shaping filter disabled and the FIFO-ready flag deasserted. It stays that way until a start event is accepted.

A start event comes from one of two places. The first is an edge on the external `sync_in` pin, where a configuration bit chooses the rising or the falling edge. The second is a write to the low byte of the sampling-oscillator centre-frequency word. The accepted start is echoed on `sync_out` as a one-cycle pulse. A master device can drive the `sync_in` pins of slave devices with it, so that all of them start on the same event.

Every reset also launches a zero-fill walk over the small I and Q sample RAMs. The walk takes the RAM port away from the datapath, sweeps all sixteen addresses with zero data, and then hands the port back.

Top module: `upc_start_seq`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, then after that edge: `run_en`=0, `nco_hold`=1, `fifo_clr`=1, `fifo_rdy_n`=1, `sync_out`=0 and `fill_busy`=1. The sync edge select also returns to rising.
- R2: A write (`wr_en`=1) to address 30 with any data has the effect of one cycle of R1, except that the edge select keeps its value.
- R3: After the last reset edge, `fill_busy` stays high for exactly 16 cycles. During those cycles `ram_addr` counts 0 to 15, one step per cycle, `ram_we`=2'b11 (bit 0 for I, bit 1 for Q) and `ram_wdata` is all zero. The walk runs to completion even if `rst_n` rises early.
- R4: While `fill_busy`=0, `ram_we`, `ram_addr` and `ram_wdata` equal `dp_we`, `dp_addr` and `dp_wdata`. The I lane is the low half of each data bus.
- R5: After any reset, `run_en` stays 0 until a start event is accepted. Start events are accepted only while halted.
- R6: `sync_in` passes through two flip-flops. A change of `sync_in` that is sampled at edge k and matches the selected polarity sets `run_en` at edge k+2. The polarity is bit 0 of the register at address 29: 0 selects rising, 1 selects falling.
- R7: An edge of `sync_in` of the other polarity has no effect.
- R8: A write to address 4 with any data starts the datapath at the edge that samples the write.
- R9: `sync_out` is high for exactly one cycle: the first cycle in which `run_en` is 1. Further start events while running produce no pulse.
- R10: A `sync_in` edge whose detection falls on a reset cycle, or a sync level held through reset, does not start the datapath.
- R11: `fifo_clr` is high only in the cycle after a reset edge. `fifo_rdy_n` is low exactly when `run_en`=1 and `fill_busy`=0. `nco_hold` is the inverse of `run_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin, sampled at the clock edge |
| sync_in | input | 1 | Asynchronous external start sync |
| wr_en | input | 1 | Control-bus write strobe |
| wr_addr | input | 5 | Control-bus word address |
| wr_data | input | 8 | Control-bus write byte |
| dp_we | input | 2 | Datapath RAM write enables {Q, I} |
| dp_addr | input | 4 | Datapath RAM address |
| dp_wdata | input | 32 | Datapath RAM write data {Q, I} |
| run_en | output | 1 | Datapath and shaping-filter enable |
| nco_hold | output | 1 | Holds the NCO accumulators at zero |
| fifo_clr | output | 1 | Clears the I/Q FIFO depth counters |
| fifo_rdy_n | output | 1 | Active-low FIFO-ready flag |
| sync_out | output | 1 | One-cycle start pulse for slave devices |
| fill_busy | output | 1 | Zero-fill walk in progress |
| ram_we | output | 2 | Sample RAM write enables {Q, I} |
| ram_addr | output | 4 | Sample RAM address |
| ram_wdata | output | 32 | Sample RAM write data {Q, I} |

## Verification
The assertions assume that `rst_n` is a synchronous level that is already low at the first clock edge. They also assume that `sync_in` changes at most once per clock period, so the history flop of the synchronizer always holds the previous sample. The bench drives every input on the falling clock edge and holds reset low from time zero. It keeps each `sync_in` level for at least two cycles and issues at most one control write per cycle, so reset commands and start writes never overlap.

// File: rtl/upc_seq_pkg.sv
// Shared types for the upconverter reset/start sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package upc_seq_pkg;

    // Datapath run state: frozen after reset, active after a start event.
    typedef enum logic [0:0] {
        RUN_HALT   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    // One-cycle strobes decoded from a control-bus write.
    typedef struct packed {
        logic rst_cmd;
        logic cfg_wr;
        logic start_wr;
    } wr_dec_t;

endpackage

// File: rtl/upc_sync_edge.sv
// Brings the asynchronous start sync into the clock domain and turns the
// selected edge into a one-cycle pulse.
// Assumes: sync_in changes at most once per clock period. The synchronizer
// flops are deliberately not reset, so a level held through reset is never
// seen as an edge once reset is released.
module upc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic fall_sel,
    output logic edge_pulse
);

    logic chain [0:STAGES];
    logic rise_det;
    logic fall_det;

    // First synchronizer stage samples the pin.
    always_ff @(posedge clk) begin
        chain[0] <= async_in;
    end

    // Remaining synchronizer stages plus one history flop.
    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            chain[g] <= chain[g-1];
        end
    end

    // Edge detection on the synchronized level.
    always_comb begin
        rise_det   = chain[STAGES-1] & ~chain[STAGES];
        fall_det   = ~chain[STAGES-1] & chain[STAGES];
        edge_pulse = fall_sel ? fall_det : rise_det;
    end

    // R6: a detected rising edge cannot repeat on the next cycle.
    a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_det |=> !rise_det);

    // R6: a detected falling edge cannot repeat on the next cycle.
    a_r6_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_det |=> !fall_det);

endmodule

// File: rtl/upc_cmd_decode.sv
// Decodes control-bus writes into reset, configuration and start strobes,
// and holds the sync polarity configuration bit.
// Assumes: at most one write per cycle; write data matters only for the
// configuration word.
module upc_cmd_decode
    import upc_seq_pkg::*;
#(
    parameter int          AW         = 5,
    parameter int          DW         = 8,
    parameter logic [AW-1:0] RST_ADDR   = 5'd30,
    parameter logic [AW-1:0] CFG_ADDR   = 5'd29,
    parameter logic [AW-1:0] START_ADDR = 5'd4,
    parameter int          EDGE_BIT   = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output wr_dec_t       dec,
    output logic          fall_sel
);

    logic unused_wr_data;

    // Address match for each of the three words this block owns.
    always_comb begin
        dec.rst_cmd  = wr_en && (wr_addr == RST_ADDR);
        dec.cfg_wr   = wr_en && (wr_addr == CFG_ADDR);
        dec.start_wr = wr_en && (wr_addr == START_ADDR);
    end

    // Only the polarity bit of the configuration byte is stored.
    assign unused_wr_data = ^wr_data;

    // Polarity register: pin reset selects rising, command reset keeps it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_sel <= 1'b0;
        end else if (dec.cfg_wr) begin
            fall_sel <= wr_data[EDGE_BIT];
        end
    end

    // R1: the pin reset returns the edge select to rising.
    a_r1_cfg_default: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !fall_sel);

    // R2: a reset command leaves the edge select untouched.
    a_r2_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        dec.rst_cmd |=> $stable(fall_sel));

endmodule

// File: rtl/upc_zero_fill.sv
// Zero-fill walker for the I and Q sample RAMs. On each reset it takes the
// RAM port, writes zeros to every address in ascending order, then returns
// the port to the datapath.
// Assumes: DEPTH is a power of two. Reset held longer than one cycle keeps
// the walk parked at address zero.
module upc_zero_fill #(
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    parameter int LANES = 2,
    localparam int FAW  = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic [LANES-1:0]      dp_we,
    input  logic [FAW-1:0]        dp_addr,
    input  logic [LANES*DW-1:0]   dp_wdata,
    output logic                  busy,
    output logic [LANES-1:0]      ram_we,
    output logic [FAW-1:0]        ram_addr,
    output logic [LANES*DW-1:0]   ram_wdata
);

    localparam logic [FAW-1:0] LAST = FAW'(DEPTH - 1);

    logic [FAW-1:0] fill_addr;

    // Walk counter: park at zero in reset, step once per cycle, stop at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            busy      <= 1'b1;
            fill_addr <= '0;
        end else if (busy) begin
            if (fill_addr == LAST) begin
                busy <= 1'b0;
            end else begin
                fill_addr <= fill_addr + 1'b1;
            end
        end
    end

    // Shared address: walker while busy, datapath otherwise.
    assign ram_addr = busy ? fill_addr : dp_addr;

    // Per-lane port steering with forced-zero data during the walk.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            ram_we[l]              = busy | dp_we[l];
            ram_wdata[l*DW +: DW]  = busy ? '0 : dp_wdata[l*DW +: DW];
        end
    end

    // R3: the walk advances one address per cycle.
    a_r3_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !restart && fill_addr != LAST)
            |=> (busy && fill_addr == FAW'($past(fill_addr) + 1'b1)));

    // R3: the walk ends right after the last address.
    a_r3_walk_end: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !restart && fill_addr == LAST) |=> !busy);

    // R3: a reset command restarts the walk at address zero.
    a_r3_walk_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (busy && fill_addr == '0));

    // R3: an idle walker stays idle without a reset.
    a_r3_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !restart) |=> !busy);

endmodule

// File: rtl/upc_run_ctrl.sv
// Run-state controller: freezes the datapath on any reset, accepts the first
// start event afterwards, and produces the run enable, NCO hold, FIFO clear,
// FIFO-ready flag and the chaining sync pulse.
// Assumes: start_wr and rst_cmd never coincide (they share one bus).
module upc_run_ctrl
    import upc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rst_cmd,
    input  logic start_wr,
    input  logic pin_pulse,
    input  logic fill_busy,
    output logic run_en,
    output logic nco_hold,
    output logic fifo_clr,
    output logic fifo_rdy_n,
    output logic sync_out
);

    run_state_e state;
    logic       accept;

    // A start is taken only while halted; reset has priority in the flops.
    assign accept = (state == RUN_HALT) && (start_wr || pin_pulse);

    // Run state, sync pulse and FIFO clear, with both reset sources.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_cmd) begin
            state    <= RUN_HALT;
            sync_out <= 1'b0;
            fifo_clr <= 1'b1;
        end else begin
            fifo_clr <= 1'b0;
            sync_out <= accept;
            if (accept) begin
                state <= RUN_ACTIVE;
            end
        end
    end

    // Decoded outputs of the run state and the fill walk.
    always_comb begin
        run_en     = (state == RUN_ACTIVE);
        nco_hold   = (state == RUN_HALT);
        fifo_rdy_n = !(run_en && !fill_busy);
    end

    // R1: the cycle after a pin reset is halted with the FIFO clear raised.
    a_r1_pin_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!run_en && fifo_clr && !sync_out));

    // R2: a reset command halts the datapath on the next cycle.
    a_r2_cmd_halts: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (!run_en && fifo_clr && !sync_out));

    // R9: the chaining pulse lasts one cycle.
    a_r9_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> !sync_out);

    // R9: the datapath starts together with the chaining pulse.
    a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> sync_out);

    // R5: once running, only a reset can halt the datapath.
    a_r5_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !rst_cmd) |=> run_en);

    // R11: the FIFO clear is never raised two cycles in a row without reset.
    a_r11_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_clr && !rst_cmd) |=> !fifo_clr);

endmodule

// File: rtl/upc_start_seq.sv
// Top of the upconverter reset/start sequencer. Wires the bus decoder, the
// sync-pin edge detector, the run controller and the RAM zero-fill walker.
// Assumes: rst_n is synchronous to clk; sync_in may be asynchronous.
module upc_start_seq
    import upc_seq_pkg::*;
#(
    parameter int            AW          = 5,
    parameter int            DW          = 8,
    parameter logic [AW-1:0] RST_ADDR    = 5'd30,
    parameter logic [AW-1:0] CFG_ADDR    = 5'd29,
    parameter logic [AW-1:0] START_ADDR  = 5'd4,
    parameter int            EDGE_BIT    = 0,
    parameter int            SYNC_STAGES = 2,
    parameter int            FILL_DEPTH  = 16,
    parameter int            RAM_DW      = 16,
    localparam int           LANES       = 2,
    localparam int           FAW         = $clog2(FILL_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sync_in,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [LANES-1:0]        dp_we,
    input  logic [FAW-1:0]          dp_addr,
    input  logic [LANES*RAM_DW-1:0] dp_wdata,
    output logic                    run_en,
    output logic                    nco_hold,
    output logic                    fifo_clr,
    output logic                    fifo_rdy_n,
    output logic                    sync_out,
    output logic                    fill_busy,
    output logic [LANES-1:0]        ram_we,
    output logic [FAW-1:0]          ram_addr,
    output logic [LANES*RAM_DW-1:0] ram_wdata
);

    wr_dec_t dec;
    logic    fall_sel;
    logic    pin_pulse;

    upc_cmd_decode #(
        .AW         (AW),
        .DW         (DW),
        .RST_ADDR   (RST_ADDR),
        .CFG_ADDR   (CFG_ADDR),
        .START_ADDR (START_ADDR),
        .EDGE_BIT   (EDGE_BIT)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .dec      (dec),
        .fall_sel (fall_sel)
    );

    upc_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (sync_in),
        .fall_sel   (fall_sel),
        .edge_pulse (pin_pulse)
    );

    upc_run_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_cmd    (dec.rst_cmd),
        .start_wr   (dec.start_wr),
        .pin_pulse  (pin_pulse),
        .fill_busy  (fill_busy),
        .run_en     (run_en),
        .nco_hold   (nco_hold),
        .fifo_clr   (fifo_clr),
        .fifo_rdy_n (fifo_rdy_n),
        .sync_out   (sync_out)
    );

    upc_zero_fill #(
        .DEPTH (FILL_DEPTH),
        .DW    (RAM_DW),
        .LANES (LANES)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (dec.rst_cmd),
        .dp_we     (dp_we),
        .dp_addr   (dp_addr),
        .dp_wdata  (dp_wdata),
        .busy      (fill_busy),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    // R10: nothing starts in the cycle after a pin reset.
    a_r10_no_start_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!sync_out && !run_en));

    // R11: the FIFO-ready flag is never asserted during the fill walk.
    a_r11_rdy_vs_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_busy |-> fifo_rdy_n);

endmodule

// File: tb/upc_start_seq_tb.sv
`timescale 1ns/1ps
module upc_start_seq_tb;

    localparam logic [4:0] A_RST   = 5'd30;
    localparam logic [4:0] A_CFG   = 5'd29;
    localparam logic [4:0] A_START = 5'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  dp_we = 2'b01;
    logic [3:0]  dp_addr = 4'd9;
    logic [31:0] dp_wdata = 32'h1234_ABCD;
    logic        run_en, nco_hold, fifo_clr, fifo_rdy_n, sync_out, fill_busy;
    logic [1:0]  ram_we;
    logic [3:0]  ram_addr;
    logic [31:0] ram_wdata;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    upc_start_seq u_dut (
        .clk (clk), .rst_n (rst_n), .sync_in (sync_in),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .dp_we (dp_we), .dp_addr (dp_addr), .dp_wdata (dp_wdata),
        .run_en (run_en), .nco_hold (nco_hold), .fifo_clr (fifo_clr),
        .fifo_rdy_n (fifo_rdy_n), .sync_out (sync_out), .fill_busy (fill_busy),
        .ram_we (ram_we), .ram_addr (ram_addr), .ram_wdata (ram_wdata)
    );

    typedef struct packed {
        logic       rst_n;
        logic       wr_en;
        logic [4:0] addr;
        logic [7:0] data;
        logic       sync;
        logic       e_run;
        logic       e_sout;
        logic       e_busy;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 5'd0,  8'h00, 1'b0, 1'b0, 1'b0, 1'b1},  // 0 pin reset
        '{1'b0, 1'b0, 5'd0,  8'h00, 1'b0, 1'b0, 1'b0, 1'b1},  // 1
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b0, 1'b0, 1'b0, 1'b1},  // 2 released
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // 3 sync rises
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // 4
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b1, 1'b1, 1'b1, 1'b1},  // 5 start
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b1, 1'b1, 1'b0, 1'b1},  // 6
        '{1'b1, 1'b1, 5'd30, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b1},  // 7 reset cmd
        '{1'b1, 1'b1, 5'd29, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1},  // 8 falling
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // 9
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b0, 1'b0, 1'b0, 1'b1},  // 10 sync falls
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b0, 1'b0, 1'b0, 1'b1},  // 11
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b0, 1'b1, 1'b1, 1'b1},  // 12 start
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b0, 1'b1, 1'b0, 1'b1},  // 13
        '{1'b0, 1'b0, 5'd0,  8'h00, 1'b0, 1'b0, 1'b0, 1'b1},  // 14 pin reset
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // 15 rise
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // 16
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b1, 1'b1, 1'b1, 1'b1},  // 17 start
        '{1'b1, 1'b1, 5'd30, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // 18 reset cmd
        '{1'b1, 1'b1, 5'd4,  8'hA5, 1'b1, 1'b1, 1'b1, 1'b1},  // 19 start write
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b1, 1'b1, 1'b0, 1'b1},  // 20
        '{1'b1, 1'b1, 5'd4,  8'h00, 1'b1, 1'b1, 1'b0, 1'b1},  // 21 no repeat
        '{1'b1, 1'b0, 5'd0,  8'h00, 1'b0, 1'b1, 1'b0, 1'b1}   // 22
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        step();
        wr_en   = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        step();
        // R1: state after a pin reset edge
        chk("R1 run_en", run_en, 0);
        chk("R1 nco_hold", nco_hold, 1);
        chk("R1 fifo_clr", fifo_clr, 1);
        chk("R1 fifo_rdy_n", fifo_rdy_n, 1);
        chk("R1 sync_out", sync_out, 0);
        chk("R1 fill_busy", fill_busy, 1);

        // Vector table: R2, R5, R6, R8, R9 over several start patterns
        for (int i = 0; i < NV; i++) begin
            rst_n   = VECS[i].rst_n;
            wr_en   = VECS[i].wr_en;
            wr_addr = VECS[i].addr;
            wr_data = VECS[i].data;
            sync_in = VECS[i].sync;
            step();
            chk($sformatf("R5/R6/R8 run_en row %0d", i), run_en, VECS[i].e_run);
            chk($sformatf("R9 sync_out row %0d", i), sync_out, VECS[i].e_sout);
            chk($sformatf("R3 fill_busy row %0d", i), fill_busy, VECS[i].e_busy);
        end
        wr_en   = 1'b0;
        sync_in = 1'b0;

        // R3: zero-fill with early reset release, then R4 hand-back
        rst_n = 1'b0;
        repeat (3) step();
        chk("R3 addr in reset", ram_addr, 0);
        rst_n = 1'b1;
        for (int k = 1; k < 16; k++) begin
            step();
            chk("R3 walk addr", ram_addr, k);
            chk("R3 walk we", ram_we, 2'b11);
            chk("R3 walk data", ram_wdata, 0);
            chk("R3 walk busy", fill_busy, 1);
        end
        step();
        chk("R3 walk done", fill_busy, 0);
        chk("R4 addr pass", ram_addr, dp_addr);
        chk("R4 we pass", ram_we, dp_we);
        chk("R4 data pass", ram_wdata, dp_wdata);

        // R10: a rising sync inside reset, level held after release
        rst_n   = 1'b0;
        sync_in = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R10 no pulse in reset", sync_out, 0);
        end
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            step();
            chk("R10 still halted", run_en, 0);
            chk("R10 no pulse", sync_out, 0);
        end
        bus_wr(A_START, 8'h00);
        chk("R8 write start", run_en, 1);
        chk("R9 pulse on write", sync_out, 1);
        step();
        chk("R9 pulse ends", sync_out, 0);

        // R11: ready flag waits for the fill walk
        chk("R11 rdy during fill", fifo_rdy_n, 1);
        chk("R11 hold released", nco_hold, 0);
        repeat (6) step();
        chk("R11 fill ended", fill_busy, 0);
        chk("R11 rdy low", fifo_rdy_n, 0);
        chk("R11 clr idle", fifo_clr, 0);

        // R7 and R2: falling select survives a reset command
        sync_in = 1'b0;
        repeat (3) step();
        bus_wr(A_CFG, 8'h01);
        bus_wr(A_RST, 8'hFF);
        chk("R2 cmd halts", run_en, 0);
        chk("R2 cmd clears fifo", fifo_clr, 1);
        chk("R2 cmd hold", nco_hold, 1);
        chk("R2 cmd rdy", fifo_rdy_n, 1);
        step();
        chk("R11 clr one cycle", fifo_clr, 0);
        sync_in = 1'b1;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R7 rising ignored", run_en, 0);
        end
        sync_in = 1'b0;
        step();
        step();
        chk("R6 not yet", run_en, 0);
        step();
        chk("R6 falling start", run_en, 1);
        chk("R9 falling pulse", sync_out, 1);

        // R9: no extra pulses while running
        sync_in = 1'b1;
        repeat (2) step();
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R9 quiet rise", sync_out, 0);
        end
        sync_in = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R9 quiet fall", sync_out, 0);
            chk("R5 stays running", run_en, 1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule